// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns single bus accesses into byte cycles on an 8-bit NAND flash bus. The control for each access is packed into the access address itself. The address says whether the access is a command phase or a data phase, which opcodes to send, how many address bytes follow, and whether the operation closes with a second opcode or releases chip select. The write data carries either the address bytes or the payload. No control registers sit between the host and the flash. The only register is a small status/clear word for the ready/busy line.

In a command phase the block sends a start opcode with CLE high. It then sends up to seven address bytes from the write data, least significant byte first, with ALE high. It can finish with an end opcode, such as the confirm of a read or an erase. A command that needs more than four address bytes takes two command-phase writes. The first write carries four bytes. The second carries the rest, and the end opcode follows those remaining bytes.

In a data phase the block moves one, two or four bytes per access. A read waits a setup gap, then runs one read-enable cycle per byte and returns the bytes packed into the read data. A write can be followed by an end opcode, such as a program confirm. Either kind can release chip select. The bus handshake stalls until every flash cycle of the access is done. A rising edge on the ready/busy line sets a sticky flag that software clears.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, nf_ce_n, nf_we_n and nf_re_n are high, nf_cle, nf_ale and nf_io_oe are low, and the ready flag reads 0.
- R2: A flash access with address bit 19 = 0 is a command phase. The block sends the opcode in address bits [10:3] with CLE high. It then sends the number of address bytes given by bits [23:21] (0 to 4) from wdata, byte 0 = wdata[7:0] first, with ALE high. If bit 20 is set, it then sends the opcode in bits [18:11] with CLE high.
- R3: A command phase asking for more than 4 address bytes sends the start opcode and wdata bytes 0..3 only. The next command-phase write sends the remaining count of bytes from its own wdata, starting at wdata[7:0], with no start opcode. The end opcode latched by the first write follows those bytes.
- R4: A data-phase write (bit 19 = 1) sends 1, 2 or 4 bytes of wdata, least significant byte first, for bus_size 0, 1 and 2 (3 acts as 4). CLE and ALE stay low during these bytes.
- R5: A data-phase write with bit 20 set sends the opcode in bits [18:11] with CLE high after its last data byte.
- R6: A data-phase read waits the setup gap, then runs 1, 2 or 4 read cycles. Byte i is returned in bus_rdata[8i+7:8i] and the unused upper bytes are zero.
- R7: Every flash access drives nf_ce_n low. A data phase with address bit 21 set drives it high again once the access ends. Otherwise it stays low.
- R8: A write byte cycle lasts T_WC clocks with nf_we_n low for the first T_WP clocks. A read byte cycle holds nf_re_n low for T_REA+1 clocks.
- R9: bus_ready is low until all flash cycles of the access have finished. It is then high for exactly one cycle, with bus_rdata valid.
- R10: A rising edge on nf_rb sets a sticky flag. A read with address bit 24 set returns the flag in bus_rdata bit 6.
- R11: A write with address bit 24 set and wdata bit 4 = 1 clears the flag. If wdata bit 4 = 0, the flag is unchanged.
- R12: CLE and ALE are never high together, nf_we_n and nf_re_n are never low together, and the I/O bus is driven only during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Access address bits [24:3] carrying phase, opcodes, counts and flags |
| bus_wdata | input | 32 | Address bytes, payload, or clear word |
| bus_size | input | 2 | Data-phase width: 0 byte, 1 halfword, 2/3 word |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data or status word |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_io_out | output | 8 | I/O bus output value |
| nf_io_oe | output | 1 | I/O bus output enable |
| nf_io_in | input | 8 | I/O bus input value |
| nf_rb | input | 1 | Ready/busy line, high = ready |

## Verification
The bench builds the block with its default timing: a five-clock write and read cycle, a three-clock write pulse, a two-clock read access and a two-clock read setup gap. These values make every pulse width and cycle spacing measurable in whole clocks at the pins. A small flash model logs each latched byte with its CLE/ALE kind and serves a computed byte pattern on reads. Against this model the bench reaches every address-byte count, the two-write split of a five-byte address, all three data widths with and without an end opcode, and chip-select release. It also toggles ready/busy to set and clear the sticky flag.

// File: rtl/nseq_pkg.sv
// Shared types for the NAND command sequencer.
// Assumes the fixed address-field layout described in the brief.
package nseq_pkg;

    // kind of one byte cycle on the flash bus
    typedef enum logic [1:0] {
        CY_CMD  = 2'd0,
        CY_ADDR = 2'd1,
        CY_WR   = 2'd2,
        CY_RD   = 2'd3
    } cyc_kind_t;

    // fields carried in the access address
    typedef struct packed {
        logic       regsp;
        logic [2:0] ncyc;
        logic       endv;
        logic       data_ph;
        logic [7:0] endop;
        logic [7:0] startop;
        logic       rel_cs;
    } acc_fields_t;

    // number of flash bytes for a data-phase bus size code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/nseq_addr_decode.sv
// Splits the access address into its control fields.
// Assumes bits [24:3] of the bus address; the low three bits carry nothing.
module nseq_addr_decode
    import nseq_pkg::*;
(
    input  logic [24:3]  addr,
    output acc_fields_t  fld
);
    // pure field extraction
    always_comb begin
        fld.regsp   = addr[24];
        fld.ncyc    = addr[23:21];
        fld.endv    = addr[20];
        fld.data_ph = addr[19];
        fld.endop   = addr[18:11];
        fld.startop = addr[10:3];
        fld.rel_cs  = addr[21];
    end
endmodule

// File: rtl/nseq_cycle_engine.sv
// Runs one byte cycle on the flash bus: command, address, data write or
// data read. Assumes req is held until ack; a new cycle starts on the clock
// after ack when req is high again.
module nseq_cycle_engine
    import nseq_pkg::*;
#(
    parameter int T_WC  = 5,
    parameter int T_WP  = 3,
    parameter int T_RC  = 5,
    parameter int T_REA = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  cyc_kind_t  kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] io_in,
    output logic       ack,
    output logic [7:0] rbyte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic       io_oe,
    output logic [7:0] io_out
);
    localparam int TMAX = (T_WC > T_RC) ? T_WC : T_RC;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] WLAST = CW'(T_WC - 1);
    localparam logic [CW-1:0] RLAST = CW'(T_RC - 1);
    localparam logic [CW-1:0] WPULS = CW'(T_WP);
    localparam logic [CW-1:0] RSAMP = CW'(T_REA);

    logic          active;
    cyc_kind_t     knd;
    logic [CW-1:0] cnt;
    logic [7:0]    byte_q;
    logic [7:0]    rcap;
    logic [CW-1:0] last;

    // last count of the running cycle
    always_comb last = (knd == CY_RD) ? RLAST : WLAST;

    // cycle state: start on request, count to the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            knd    <= CY_CMD;
            cnt    <= '0;
            byte_q <= '0;
        end else if (!active) begin
            if (req) begin
                active <= 1'b1;
                knd    <= kind;
                byte_q <= wbyte;
                cnt    <= '0;
            end
        end else if (cnt == last) begin
            active <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // read capture at the end of the access time
    always_ff @(posedge clk) begin
        if (!rst_n)
            rcap <= '0;
        else if (active && knd == CY_RD && cnt == RSAMP)
            rcap <= io_in;
    end

    // pin levels decoded from the cycle state
    always_comb begin
        ack    = active && (cnt == last);
        rbyte  = rcap;
        cle    = active && (knd == CY_CMD);
        ale    = active && (knd == CY_ADDR);
        we_n   = !(active && (knd != CY_RD) && (cnt < WPULS));
        re_n   = !(active && (knd == CY_RD) && (cnt <= RSAMP));
        io_oe  = active && (knd != CY_RD);
        io_out = byte_q;
    end

    // R8
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) && active) |-> (cnt == WPULS));
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
endmodule

// File: rtl/nseq_rb_watch.sv
// Synchronises the ready/busy line and keeps a sticky flag set by each
// rising edge. Assumes the line idles high; a set wins over a clear.
module nseq_rb_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    input  logic clr,
    output logic flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;

    // synchroniser chain and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rb_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // edge detect
    always_comb rise = sync_q[SYNC_STAGES-1] && !prev_q;

    // sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (rise)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R10
    rb_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> flag);
    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !flag);
endmodule

// File: rtl/nand_cmd_seq.sv
// NAND flash command sequencer. Each bus access carries its own control in
// the address. The access is expanded into command, address and data byte
// cycles, and the bus is stalled until they finish. Assumes the host holds
// bus_valid and its fields steady until bus_ready.
module nand_cmd_seq
    import nseq_pkg::*;
#(
    parameter int T_WC  = 5,
    parameter int T_RC  = 5,
    parameter int T_WP  = 3,
    parameter int T_REA = 2,
    parameter int T_CLR = 1,
    parameter int T_AR  = 2,
    parameter int T_RR  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [24:3] bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [1:0]  bus_size,
    output logic        bus_ready,
    output logic [31:0] bus_rdata,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic        nf_ce_n,
    output logic [7:0]  nf_io_out,
    output logic        nf_io_oe,
    input  logic [7:0]  nf_io_in,
    input  logic        nf_rb
);
    localparam int GAP_A = (T_CLR > T_AR) ? T_CLR : T_AR;
    localparam int GAP   = (GAP_A > T_RR) ? GAP_A : T_RR;
    localparam int GW    = $clog2(GAP + 1) + 1;
    localparam logic [GW-1:0] GLAST = GW'(GAP - 1);
    localparam int ADDR_SPLIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_END,
        ST_WDATA, ST_GAP, ST_RDATA, ST_DONE
    } seq_state_t;

    acc_fields_t dec;
    acc_fields_t f;
    seq_state_t  st;
    logic [31:0] wd;
    logic [31:0] rdata_q;
    logic [2:0]  idx;
    logic [2:0]  addr_left;
    logic [2:0]  nby;
    logic [2:0]  cont_left;
    logic [7:0]  cont_endop;
    logic        cont_endv;
    logic [7:0]  cur_endop;
    logic        cur_endv;
    logic        ce_n_q;
    logic [GW-1:0] gapcnt;
    logic        accept;
    logic        flag;
    logic        clr;
    logic        eng_req;
    cyc_kind_t   eng_kind;
    logic [7:0]  eng_byte;
    logic        eng_ack;
    logic [7:0]  eng_rbyte;
    logic        idx_last_addr;
    logic        idx_last_data;

    nseq_addr_decode u_dec (
        .addr (bus_addr),
        .fld  (dec)
    );

    nseq_rb_watch #(.SYNC_STAGES(2)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nf_rb),
        .clr      (clr),
        .flag     (flag)
    );

    nseq_cycle_engine #(
        .T_WC(T_WC), .T_WP(T_WP), .T_RC(T_RC), .T_REA(T_REA)
    ) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (eng_req),
        .kind   (eng_kind),
        .wbyte  (eng_byte),
        .io_in  (nf_io_in),
        .ack    (eng_ack),
        .rbyte  (eng_rbyte),
        .cle    (nf_cle),
        .ale    (nf_ale),
        .we_n   (nf_we_n),
        .re_n   (nf_re_n),
        .io_oe  (nf_io_oe),
        .io_out (nf_io_out)
    );

    // acceptance and register-space clear strobe
    always_comb begin
        accept = (st == ST_IDLE) && bus_valid;
        clr    = accept && dec.regsp && bus_write && bus_wdata[4];
        idx_last_addr = ((idx + 3'd1) == addr_left);
        idx_last_data = ((idx + 3'd1) == nby);
    end

    // byte-cycle request toward the engine for the current step
    always_comb begin
        eng_req  = 1'b0;
        eng_kind = CY_CMD;
        eng_byte = 8'h00;
        case (st)
            ST_START: begin eng_req = 1'b1; eng_kind = CY_CMD;  eng_byte = f.startop; end
            ST_ADDR:  begin eng_req = 1'b1; eng_kind = CY_ADDR; eng_byte = wd[{idx[1:0], 3'b000} +: 8]; end
            ST_END:   begin eng_req = 1'b1; eng_kind = CY_CMD;  eng_byte = cur_endop; end
            ST_WDATA: begin eng_req = 1'b1; eng_kind = CY_WR;   eng_byte = wd[{idx[1:0], 3'b000} +: 8]; end
            ST_RDATA: begin eng_req = 1'b1; eng_kind = CY_RD;   eng_byte = 8'h00; end
            default:  ;
        endcase
    end

    // step sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            f          <= '0;
            wd         <= '0;
            rdata_q    <= '0;
            idx        <= '0;
            addr_left  <= '0;
            nby        <= '0;
            cont_left  <= '0;
            cont_endop <= '0;
            cont_endv  <= 1'b0;
            cur_endop  <= '0;
            cur_endv   <= 1'b0;
            ce_n_q     <= 1'b1;
            gapcnt     <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    f       <= dec;
                    wd      <= bus_wdata;
                    idx     <= '0;
                    gapcnt  <= '0;
                    rdata_q <= '0;
                    if (dec.regsp) begin
                        rdata_q <= {25'd0, flag, 6'd0};
                        st      <= ST_DONE;
                    end else begin
                        ce_n_q <= 1'b0;
                        if (!dec.data_ph) begin
                            if (cont_left != 3'd0) begin
                                addr_left <= cont_left;
                                cur_endv  <= cont_endv;
                                cur_endop <= cont_endop;
                                cont_left <= '0;
                                st        <= ST_ADDR;
                            end else begin
                                cur_endop <= dec.endop;
                                if (dec.ncyc > 3'(ADDR_SPLIT)) begin
                                    addr_left  <= 3'(ADDR_SPLIT);
                                    cont_left  <= dec.ncyc - 3'(ADDR_SPLIT);
                                    cont_endv  <= dec.endv;
                                    cont_endop <= dec.endop;
                                    cur_endv   <= 1'b0;
                                end else begin
                                    addr_left <= dec.ncyc;
                                    cur_endv  <= dec.endv;
                                end
                                st <= ST_START;
                            end
                        end else begin
                            nby       <= size_bytes(bus_size);
                            cur_endv  <= dec.endv;
                            cur_endop <= dec.endop;
                            if (bus_write)
                                st <= ST_WDATA;
                            else if (GAP > 0)
                                st <= ST_GAP;
                            else
                                st <= ST_RDATA;
                        end
                    end
                end
                ST_START: if (eng_ack) begin
                    if (addr_left != 3'd0) st <= ST_ADDR;
                    else if (cur_endv)     st <= ST_END;
                    else                   st <= ST_DONE;
                end
                ST_ADDR: if (eng_ack) begin
                    idx <= idx + 3'd1;
                    if (idx_last_addr)
                        st <= cur_endv ? ST_END : ST_DONE;
                end
                ST_END: if (eng_ack) st <= ST_DONE;
                ST_WDATA: if (eng_ack) begin
                    idx <= idx + 3'd1;
                    if (idx_last_data)
                        st <= cur_endv ? ST_END : ST_DONE;
                end
                ST_GAP: begin
                    gapcnt <= gapcnt + 1'b1;
                    if (gapcnt == GLAST) st <= ST_RDATA;
                end
                ST_RDATA: if (eng_ack) begin
                    rdata_q[{idx[1:0], 3'b000} +: 8] <= eng_rbyte;
                    idx <= idx + 3'd1;
                    if (idx_last_data) st <= ST_DONE;
                end
                ST_DONE: begin
                    if (!f.regsp && f.data_ph && f.rel_cs)
                        ce_n_q <= 1'b1;
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // bus-side outputs
    always_comb begin
        bus_ready = (st == ST_DONE);
        bus_rdata = rdata_q;
        nf_ce_n   = ce_n_q;
    end

    // R12
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));
    // R12
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_io_oe);
    // R7
    ce_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);
    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    // R9
    ready_idle_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (nf_we_n && nf_re_n));
endmodule

// File: tb/nand_cmd_seq_test.sv
`timescale 1ns/1ps
module nand_cmd_seq_test;
    localparam int T_WC = 5, T_RC = 5, T_WP = 3, T_REA = 2;
    localparam real PER = 20.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [24:0] full_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_ce_n, nf_io_oe;
    logic [7:0]  nf_io_out, nf_io_in;
    logic        nf_rb = 1'b1;

    int checks = 0, errors = 0;
    int lcnt = 0, rd_idx = 0;
    logic [1:0] lk [0:1023];
    logic [7:0] lb [0:1023];
    logic [1:0] ek [0:15];
    logic [7:0] eb [0:15];
    int en;
    realtime t_wf = -1000.0, t_rf = 0.0;
    bit finished = 0;

    always #10 clk = ~clk;

    nand_cmd_seq #(.T_WC(T_WC), .T_RC(T_RC), .T_WP(T_WP), .T_REA(T_REA)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(full_addr[24:3]), .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_ce_n(nf_ce_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
        .nf_io_in(nf_io_in), .nf_rb(nf_rb)
    );

    function automatic logic [7:0] rd_pat(input int k);
        return 8'(k * 29 + 53);
    endfunction
    assign nf_io_in = rd_pat(rd_idx);

    function automatic logic [24:0] mk_cmd(input logic [7:0] s, input logic [7:0] e,
                                           input logic ev, input logic [2:0] n);
        return {1'b0, n, ev, 1'b0, e, s, 3'b000};
    endfunction
    function automatic logic [24:0] mk_dat(input logic [7:0] e, input logic ev,
                                           input logic rel);
        return {1'b0, 2'b00, rel, ev, 1'b1, e, 8'h00, 3'b000};
    endfunction
    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model: log each latched byte with its kind (1 cmd, 2 addr, 0 data)
    always @(posedge nf_we_n) if (rst_n) begin
        if (lcnt < 1024) begin
            lk[lcnt] = nf_cle ? 2'd1 : (nf_ale ? 2'd2 : 2'd0);
            lb[lcnt] = nf_io_out;
            lcnt++;
        end
        // R8 write pulse width
        chk(($realtime - t_wf) == T_WP * PER, "R8 we_low",
            32'(int'(($realtime - t_wf) / PER)), T_WP);
    end
    always @(negedge nf_we_n) if (rst_n) begin
        // R8 write cycle spacing
        chk(($realtime - t_wf) >= T_WC * PER, "R8 we_period",
            32'(int'(($realtime - t_wf) / PER)), T_WC);
        t_wf = $realtime;
    end
    always @(negedge nf_re_n) if (rst_n) t_rf = $realtime;
    always @(posedge nf_re_n) if (rst_n) begin
        rd_idx++;
        chk(($realtime - t_rf) == (T_REA + 1) * PER, "R8 re_low",
            32'(int'(($realtime - t_rf) / PER)), T_REA + 1);
    end

    task automatic bus_op(input logic wr, input logic [24:0] a, input logic [31:0] d,
                          input logic [1:0] sz, output logic [31:0] rd, output int waited);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; full_addr = a; bus_wdata = d; bus_size = sz;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!bus_ready && waited < 5000);
        rd = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic log_chk(input int base, input string req);
        bit ok = (lcnt - base) == en;
        chk(ok, {req, " log_len"}, 32'(lcnt - base), 32'(en));
        if (ok) for (int i = 0; i < en; i++)
            chk(lk[base+i] == ek[i] && lb[base+i] == eb[i], {req, " log_byte"},
                {22'd0, lk[base+i], lb[base+i]}, {22'd0, ek[i], eb[i]});
    endtask

    task automatic exp_cmd(input logic [7:0] s, input logic [7:0] e, input logic ev,
                           input int n, input logic [31:0] d);
        en = 0;
        ek[en] = 2'd1; eb[en] = s; en++;
        for (int i = 0; i < n; i++) begin ek[en] = 2'd2; eb[en] = d[8*i +: 8]; en++; end
        if (ev) begin ek[en] = 2'd1; eb[en] = e; en++; end
    endtask

    task automatic exp_wr(input logic [7:0] e, input logic ev, input int n,
                          input logic [31:0] d);
        en = 0;
        for (int i = 0; i < n; i++) begin ek[en] = 2'd0; eb[en] = d[8*i +: 8]; en++; end
        if (ev) begin ek[en] = 2'd1; eb[en] = e; en++; end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, expv;
        int w, base, k0;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_io_oe && !bus_ready,
            "R1 pins", {25'd0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe, bus_ready},
            32'h70);
        bus_op(1'b0, 25'h1000000, 0, 0, rd, w);
        chk(rd[6] == 1'b0, "R1 flag", rd, 0);

        // R2 command with 3 address bytes and end opcode
        base = lcnt;
        bus_op(1'b1, mk_cmd(8'h60, 8'hD0, 1'b1, 3'd3), 32'h00ABCDEF, 0, rd, w);
        exp_cmd(8'h60, 8'hD0, 1'b1, 3, 32'h00ABCDEF);
        log_chk(base, "R2");
        // R9 stall covers all five byte cycles
        chk(w >= 5 * T_WC, "R9 stall", 32'(w), 32'(5 * T_WC));
        // R7 chip enable held low
        chk(nf_ce_n == 1'b0, "R7 ce_low", {31'd0, nf_ce_n}, 0);
        // R12 idle pins
        chk(!nf_cle && !nf_ale && !nf_io_oe, "R12 idle",
            {29'd0, nf_cle, nf_ale, nf_io_oe}, 0);

        // R2 zero address bytes, no end opcode
        base = lcnt;
        bus_op(1'b1, mk_cmd(8'hFF, 8'h00, 1'b0, 3'd0), 32'h0, 0, rd, w);
        exp_cmd(8'hFF, 8'h00, 1'b0, 0, 0);
        log_chk(base, "R2 zero_addr");

        // R3 five-byte address split over two writes
        base = lcnt;
        bus_op(1'b1, mk_cmd(8'h00, 8'h30, 1'b1, 3'd5), 32'h44332211, 0, rd, w);
        exp_cmd(8'h00, 8'h30, 1'b0, 4, 32'h44332211);
        log_chk(base, "R3 first");
        base = lcnt;
        bus_op(1'b1, mk_cmd(8'h00, 8'h30, 1'b1, 3'd5), 32'h00000055, 0, rd, w);
        en = 0;
        ek[0] = 2'd2; eb[0] = 8'h55; ek[1] = 2'd1; eb[1] = 8'h30; en = 2;
        log_chk(base, "R3 second");

        // R6 read two bytes, after the setup gap
        k0 = rd_idx;
        bus_op(1'b0, mk_dat(8'h00, 1'b0, 1'b0), 0, 2'd1, rd, w);
        expv = {16'd0, rd_pat(k0 + 1), rd_pat(k0)};
        chk(rd == expv, "R6 half_read", rd, expv);

        // R4/R5 word write + end opcode, R7 release
        base = lcnt;
        bus_op(1'b1, mk_dat(8'h10, 1'b1, 1'b1), 32'hCAFE1234, 2'd2, rd, w);
        exp_wr(8'h10, 1'b1, 4, 32'hCAFE1234);
        log_chk(base, "R5");
        @(negedge clk);
        chk(nf_ce_n == 1'b1, "R7 release", {31'd0, nf_ce_n}, 1);

        // R7 next access drives CE low again; R6 byte read
        k0 = rd_idx;
        bus_op(1'b0, mk_dat(8'h00, 1'b0, 1'b0), 0, 2'd0, rd, w);
        chk(rd == {24'd0, rd_pat(k0)}, "R6 byte_read", rd, {24'd0, rd_pat(k0)});
        chk(nf_ce_n == 1'b0, "R7 ce_relow", {31'd0, nf_ce_n}, 0);

        // R10 ready edge sets flag
        nf_rb = 1'b0; repeat (10) @(negedge clk);
        nf_rb = 1'b1; repeat (6) @(negedge clk);
        bus_op(1'b0, 25'h1000000, 0, 0, rd, w);
        chk(rd == 32'h40, "R10 flag_set", rd, 32'h40);
        // R11 write without bit 4 leaves flag
        bus_op(1'b1, 25'h1000000, 32'hFFFFFFEF, 0, rd, w);
        bus_op(1'b0, 25'h1000000, 0, 0, rd, w);
        chk(rd[6] == 1'b1, "R11 no_clear", rd, 32'h40);
        // R11 clear
        bus_op(1'b1, 25'h1000000, 32'h10, 0, rd, w);
        bus_op(1'b0, 25'h1000000, 0, 0, rd, w);
        chk(rd[6] == 1'b0, "R11 cleared", rd, 0);

        // random mix: R2 R4 R5 R6
        for (int it = 0; it < 40; it++) begin
            int sel = $urandom_range(0, 2);
            logic [31:0] d = $urandom;
            logic [7:0] s = 8'($urandom), e = 8'($urandom);
            logic ev = 1'($urandom);
            logic [1:0] sz = 2'($urandom_range(0, 3));
            if (sel == 0) begin
                int n = $urandom_range(0, 4);
                base = lcnt;
                bus_op(1'b1, mk_cmd(s, e, ev, 3'(n)), d, 0, rd, w);
                exp_cmd(s, e, ev, n, d);
                log_chk(base, "R2 rand");
            end else if (sel == 1) begin
                base = lcnt;
                bus_op(1'b1, mk_dat(e, ev, 1'b0), d, sz, rd, w);
                exp_wr(e, ev, nbytes(sz), d);
                log_chk(base, "R4 rand");
            end else begin
                k0 = rd_idx;
                bus_op(1'b0, mk_dat(e, 1'b0, 1'b0), 0, sz, rd, w);
                expv = 0;
                for (int i = 0; i < nbytes(sz); i++) expv[8*i +: 8] = rd_pat(k0 + i);
                chk(rd == expv, "R6 rand", rd, expv);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule